// File: doc/BRIEF.md
# Flash command interface decoder

This block is the command front end of a NOR-style flash device. It watches write bus cycles. The low byte of each write carries a command code, and the block decodes one-cycle and two-cycle command sequences from those codes. It keeps track of what a read should return: the array, the identifier, the query table or the status byte. It starts program, erase, buffered program, factory program and block lock operations by pulsing a request that carries the operation kind, the latched address and the latched data.

Program, erase, buffered program and factory program operations occupy an internal timer for a fixed number of cycles. While the timer runs, the block is busy and takes only a suspend command. A suspended operation keeps its remaining time and continues when it is resumed.

An active-low reset aborts everything. The reset is applied asynchronously and released on a clock edge. After release, the block refuses all reads and writes until a wake-up interval has passed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset is released, `awake` stays low for exactly WAKE_CYCLES+2 rising edges, with 2 edges of reset synchronisation and WAKE_CYCLES of wake-up delay. While it is low, writes are ignored and `rd_grant` stays low. After that, `rd_grant` equals `rd_en`.
- R2: A write of 0xFF, 0x90, 0x98 or 0x70 at any address sets `rd_mode` to 0 (array), 1 (identifier), 2 (query) or 3 (status). The mode holds until another mode change occurs.
- R3: A write of 0x50 at any address clears the sequence-error flag, which is status bit 4.
- R4: A setup write of 0x40 or 0x10, followed by any write, pulses `op_req` for one cycle with `op_kind`=1 and with the address and data of the second write. It also sets `rd_mode` to 3.
- R5: A write of 0x20, followed by a write of 0xD0, requests `op_kind`=2 at the address of the 0xD0 write.
- R6: A write of 0x60, followed by a write of 0x01, 0xD0 or 0x2F, requests `op_kind` 5 (lock), 6 (unlock) or 7 (lock-down) at the address of the 0x60 write. A lock operation never makes the block busy.
- R7: A write of 0xE8 starts a buffered program. The next write carries a count C in the range 0..BUF_MAX-1, followed by C+1 data writes. After the last data write, `op_kind`=3 is requested with the address of the 0xE8 write and data C. A count above BUF_MAX-1 is a sequence error.
- R8: A write of 0x80, followed by a write of 0xD0, requests `op_kind`=4 at the address of the 0xD0 write.
- R9: A wrong second-cycle code after 0x20, 0x60 or 0x80 sets status bit 4. The block then raises no request and sets `rd_mode` to 3.
- R10: Status bit 7 is 0 for exactly OP_CYCLES cycles after a program, erase, buffered or factory program launch, and then returns to 1. While busy, every write other than 0xB0 is ignored.
- R11: A write of 0xB0 while busy suspends the operation. Status bit 7 then reads 1, and bit 6 (erase) or bit 2 (any program kind) is set. A write of 0xD0 while suspended resumes the operation, which finishes after the cycles it had left. While suspended, only 0xFF, 0x70, 0x90, 0x98, 0x50 and 0xD0 take effect.
- R12: Asserting reset during an operation aborts it. After wake-up, status reads 0x80, `rd_mode` is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; command code in bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_grant | output | 1 | Read accepted (read strobe while awake) |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| awake | output | 1 | Wake-up interval over, bus accesses accepted |
| op_req | output | 1 | One-cycle operation request |
| op_kind | output | 3 | Operation kind of the last request |
| op_addr | output | AW | Address of the last request |
| op_data | output | DW | Data of the last request |
| status | output | 8 | Status byte: 7 ready, 6 erase suspended, 4 sequence error, 2 program suspended |

## Verification
The bench builds the block with WAKE_CYCLES=6, OP_CYCLES=10 and BUF_MAX=8, with 16-bit address and data. The short wake-up interval and operation time let the bench count the exact edge at which `awake` rises and at which the ready bit returns, both before and after a suspend. The small buffer limit puts the largest legal count, and the first count that must be rejected, within a few writes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_QUERY  = 2'd2,
    RM_STATUS = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_PROG     = 3'd1,
    OP_ERASE    = 3'd2,
    OP_BUFPROG  = 3'd3,
    OP_EFP      = 3'd4,
    OP_LOCK     = 3'd5,
    OP_UNLOCK   = 3'd6,
    OP_LOCKDOWN = 3'd7
  } op_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PROG,
    SQ_ERASE,
    SQ_LOCK,
    SQ_BCOUNT,
    SQ_BDATA,
    SQ_EFP
  } seq_e;

  localparam logic [7:0] C_MODE_ARRAY  = 8'hFF;
  localparam logic [7:0] C_MODE_IDENT  = 8'h90;
  localparam logic [7:0] C_MODE_QUERY  = 8'h98;
  localparam logic [7:0] C_MODE_STATUS = 8'h70;
  localparam logic [7:0] C_CLR_STATUS  = 8'h50;
  localparam logic [7:0] C_PROG_A      = 8'h40;
  localparam logic [7:0] C_PROG_B      = 8'h10;
  localparam logic [7:0] C_ERASE       = 8'h20;
  localparam logic [7:0] C_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] C_BUF_SETUP   = 8'hE8;
  localparam logic [7:0] C_EFP_SETUP   = 8'h80;
  localparam logic [7:0] C_CONFIRM     = 8'hD0;
  localparam logic [7:0] C_SUSPEND     = 8'hB0;
  localparam logic [7:0] C_LOCK        = 8'h01;
  localparam logic [7:0] C_LOCKDOWN    = 8'h2F;

endpackage

// File: rtl/flash_cmd_rst_sync.sv
module flash_cmd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/flash_cmd_wake.sv
module flash_cmd_wake #(
  parameter int WAKE_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic awake
);
  localparam int WW = $clog2(WAKE_CYCLES + 1) + 1;
  localparam logic [WW-1:0] LIMIT = WW'(WAKE_CYCLES);

  logic [WW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign awake  = (cnt_q == LIMIT);
  assign cnt_en = !awake;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r1_awake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    awake |=> awake);
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/flash_cmd_op_timer.sv
module flash_cmd_op_timer #(
  parameter int OP_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic freeze,
  output logic busy
);
  localparam int TW = $clog2(OP_CYCLES + 1) + 1;
  localparam logic [TW-1:0] LOAD = TW'(OP_CYCLES);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          tick_en;

  assign tick_en = busy_q && !freeze;
  assign busy    = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (tick_en) begin
      if (cnt_q <= 1) begin
        cnt_d  = '0;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  a_r11_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && freeze && !start) |=> ($stable(cnt_q) && busy_q));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
  a_r11_no_end_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && freeze) |=> busy_q);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int WAKE_CYCLES = 100,
  parameter int OP_CYCLES   = 200,
  parameter int BUF_MAX     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic          rd_grant,
  output logic [1:0]    rd_mode,
  output logic          awake,
  output logic          op_req,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic [7:0]    status
);
  localparam int CW = $clog2(BUF_MAX) + 1;
  localparam logic [DW-1:0] BUF_TOP = DW'(BUF_MAX - 1);

  logic srst_n;
  logic busy;
  logic tmr_start;

  seq_e          seq_q, seq_d;
  rd_mode_e      mode_q, mode_d;
  op_kind_e      kind_q, kind_d;
  op_kind_e      act_q, act_d;
  logic          err_q, err_d;
  logic          susp_q, susp_d;
  logic          req_q, req_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [AW-1:0] blk_q, blk_d;
  logic [CW-1:0] remain_q, remain_d;
  logic [CW-1:0] bcnt_q, bcnt_d;

  logic          accept;
  logic [7:0]    cmd;
  logic          launch;
  op_kind_e      l_kind;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_data;
  logic          seq_fail;
  logic          timed;

  flash_cmd_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  flash_cmd_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk   (clk),
    .rst_n (srst_n),
    .awake (awake)
  );

  flash_cmd_op_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (tmr_start),
    .freeze (susp_q),
    .busy   (busy)
  );

  assign accept = wr_en && awake;
  assign cmd    = wr_data[7:0];

  // Command decoding: which sequence step, launch or error this write causes
  always_comb begin
    seq_d    = seq_q;
    mode_d   = mode_q;
    err_d    = err_q;
    susp_d   = susp_q;
    blk_d    = blk_q;
    remain_d = remain_q;
    bcnt_d   = bcnt_q;
    launch   = 1'b0;
    l_kind   = OP_NONE;
    l_addr   = wr_addr;
    l_data   = wr_data;
    seq_fail = 1'b0;
    if (accept) begin
      if (busy && !susp_q) begin
        if (cmd == C_SUSPEND) susp_d = 1'b1;
      end else if (susp_q) begin
        case (cmd)
          C_MODE_ARRAY:  mode_d = RM_ARRAY;
          C_MODE_IDENT:  mode_d = RM_IDENT;
          C_MODE_QUERY:  mode_d = RM_QUERY;
          C_MODE_STATUS: mode_d = RM_STATUS;
          C_CLR_STATUS:  err_d  = 1'b0;
          C_CONFIRM: begin
            susp_d = 1'b0;
            mode_d = RM_STATUS;
          end
          default: ;
        endcase
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            blk_d = wr_addr;
            case (cmd)
              C_MODE_ARRAY:       mode_d = RM_ARRAY;
              C_MODE_IDENT:       mode_d = RM_IDENT;
              C_MODE_QUERY:       mode_d = RM_QUERY;
              C_MODE_STATUS:      mode_d = RM_STATUS;
              C_CLR_STATUS:       err_d  = 1'b0;
              C_PROG_A, C_PROG_B: seq_d  = SQ_PROG;
              C_ERASE:            seq_d  = SQ_ERASE;
              C_LOCK_SETUP:       seq_d  = SQ_LOCK;
              C_BUF_SETUP:        seq_d  = SQ_BCOUNT;
              C_EFP_SETUP:        seq_d  = SQ_EFP;
              default: ;
            endcase
          end
          SQ_PROG: begin
            launch = 1'b1;
            l_kind = OP_PROG;
          end
          SQ_ERASE: begin
            if (cmd == C_CONFIRM) begin
              launch = 1'b1;
              l_kind = OP_ERASE;
              l_data = '0;
            end else begin
              seq_fail = 1'b1;
            end
          end
          SQ_LOCK: begin
            l_addr = blk_q;
            l_data = '0;
            case (cmd)
              C_LOCK:     begin launch = 1'b1; l_kind = OP_LOCK;     end
              C_CONFIRM:  begin launch = 1'b1; l_kind = OP_UNLOCK;   end
              C_LOCKDOWN: begin launch = 1'b1; l_kind = OP_LOCKDOWN; end
              default:    seq_fail = 1'b1;
            endcase
          end
          SQ_BCOUNT: begin
            if (wr_data > BUF_TOP) begin
              seq_fail = 1'b1;
            end else begin
              remain_d = CW'(wr_data);
              bcnt_d   = CW'(wr_data);
              seq_d    = SQ_BDATA;
            end
          end
          SQ_BDATA: begin
            if (remain_q == '0) begin
              launch = 1'b1;
              l_kind = OP_BUFPROG;
              l_addr = blk_q;
              l_data = {{(DW-CW){1'b0}}, bcnt_q};
            end else begin
              remain_d = remain_q - 1'b1;
            end
          end
          SQ_EFP: begin
            if (cmd == C_CONFIRM) begin
              launch = 1'b1;
              l_kind = OP_EFP;
              l_data = '0;
            end else begin
              seq_fail = 1'b1;
            end
          end
          default: seq_d = SQ_IDLE;
        endcase
        if (launch || seq_fail) seq_d = SQ_IDLE;
        if (seq_fail) begin
          err_d  = 1'b1;
          mode_d = RM_STATUS;
        end
      end
    end
  end

  assign timed = launch && (l_kind inside {OP_PROG, OP_ERASE, OP_BUFPROG, OP_EFP});
  assign tmr_start = timed;

  // Request outputs and the kind of the running operation
  always_comb begin
    req_d  = launch;
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    act_d  = act_q;
    if (launch) begin
      kind_d = l_kind;
      addr_d = l_addr;
      data_d = l_data;
    end
    if (timed) act_d = l_kind;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      seq_q    <= SQ_IDLE;
      mode_q   <= RM_ARRAY;
      err_q    <= 1'b0;
      susp_q   <= 1'b0;
      blk_q    <= '0;
      remain_q <= '0;
      bcnt_q   <= '0;
      req_q    <= 1'b0;
      kind_q   <= OP_NONE;
      act_q    <= OP_NONE;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      seq_q    <= seq_d;
      mode_q   <= timed ? RM_STATUS : mode_d;
      err_q    <= err_d;
      susp_q   <= susp_d;
      blk_q    <= blk_d;
      remain_q <= remain_d;
      bcnt_q   <= bcnt_d;
      req_q    <= req_d;
      kind_q   <= kind_d;
      act_q    <= act_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  assign rd_grant = rd_en && awake;
  assign rd_mode  = mode_q;
  assign op_req   = req_q;
  assign op_kind  = kind_q;
  assign op_addr  = addr_q;
  assign op_data  = data_q;
  assign status   = {(!busy || susp_q),
                     (susp_q && act_q == OP_ERASE),
                     1'b0,
                     err_q,
                     1'b0,
                     (susp_q && act_q != OP_ERASE),
                     2'b00};

  a_r4_req_single: assert property (@(posedge clk) disable iff (!srst_n)
    op_req |=> !op_req);
  a_r10_busy_no_req: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !susp_q) |=> !op_req);
  a_r10_launch_busy: assert property (@(posedge clk) disable iff (!srst_n)
    (op_req && op_kind inside {3'd1, 3'd2, 3'd3, 3'd4}) |-> (!status[7] && rd_mode == 2'd3));
  a_r6_lock_ready: assert property (@(posedge clk) disable iff (!srst_n)
    (op_req && op_kind >= 3'd5 && !$past(busy)) |-> status[7]);
  a_r9_err_status: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(err_q) |-> (rd_mode == 2'd3 && !op_req));
  a_r11_susp_needs_op: assert property (@(posedge clk) disable iff (!srst_n)
    susp_q |-> busy);
  a_r1_asleep_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    !awake |=> (!op_req && $stable(rd_mode)));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int AW   = 16;
  localparam int DW   = 16;
  localparam int WAKE = 6;
  localparam int OPC  = 10;
  localparam int BMAX = 8;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_en;
  logic          rd_grant;
  logic [1:0]    rd_mode;
  logic          awake;
  logic          op_req;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [7:0]    status;

  int checks;
  int errors;
  bit done;

  flash_cmd_decoder #(
    .AW(AW), .DW(DW), .WAKE_CYCLES(WAKE), .OP_CYCLES(OPC), .BUF_MAX(BMAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_grant(rd_grant),
    .rd_mode(rd_mode), .awake(awake), .op_req(op_req), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .status(status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic reset_awake();
    hold_reset();
    tick(WAKE + 2);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 4 * OPC && !status[7]; i++) tick(1);
  endtask

  // R1: wake-up interval after reset release
  task automatic t_wake();
    hold_reset();
    rd_en = 1'b1;
    bus_write(16'h0000, 16'h0070);
    tick(WAKE);
    check("R1", "awake before interval", awake, 0);
    check("R1", "rd_grant while asleep", rd_grant, 0);
    tick(1);
    check("R1", "awake after interval", awake, 1);
    check("R1", "rd_grant when awake", rd_grant, 1);
    check("R1", "write while asleep ignored", rd_mode, 0);
    rd_en = 1'b0;
    check("R12", "reset status", status, 8'h80);
    check("R12", "no request after reset", op_req, 0);
  endtask

  // R2: read mode selection
  task automatic t_modes();
    bus_write(16'h1111, 16'h0090);
    check("R2", "identifier mode", rd_mode, 1);
    tick(3);
    check("R2", "identifier mode persists", rd_mode, 1);
    bus_write(16'h2222, 16'h0098);
    check("R2", "query mode", rd_mode, 2);
    bus_write(16'h3333, 16'h0070);
    check("R2", "status mode", rd_mode, 3);
    bus_write(16'h4444, 16'h00FF);
    check("R2", "array mode", rd_mode, 0);
  endtask

  // R4 and R10: word program and busy window
  task automatic t_program();
    bus_write(16'h0100, 16'h0040);
    check("R4", "no request on setup", op_req, 0);
    bus_write(16'h1234, 16'hBEEF);
    check("R4", "request raised", op_req, 1);
    check("R4", "program kind", op_kind, 1);
    check("R4", "program address", op_addr, 16'h1234);
    check("R4", "program data", op_data, 16'hBEEF);
    check("R4", "status mode on launch", rd_mode, 3);
    check("R10", "busy on launch", status[7], 0);
    bus_write(16'h0000, 16'h0090);
    check("R4", "request is one cycle", op_req, 0);
    tick(OPC - 2);
    check("R10", "still busy at last cycle", status[7], 0);
    check("R10", "write ignored while busy", rd_mode, 3);
    tick(1);
    check("R10", "ready after interval", status[7], 1);
    bus_write(16'h0000, 16'h0010);
    bus_write(16'h0042, 16'h0007);
    check("R4", "alternate setup code", op_kind, 1);
    check("R4", "alternate setup address", op_addr, 16'h0042);
    wait_ready();
  endtask

  // R5 and R11: erase with suspend and resume
  task automatic t_erase_suspend();
    bus_write(16'h0000, 16'h00FF);
    bus_write(16'h8000, 16'h0020);
    bus_write(16'h8000, 16'h00D0);
    check("R5", "erase request", op_req, 1);
    check("R5", "erase kind", op_kind, 2);
    check("R5", "erase address", op_addr, 16'h8000);
    tick(3);
    bus_write(16'h0000, 16'h00B0);
    check("R11", "ready while suspended", status[7], 1);
    check("R11", "erase suspended bit", status[6], 1);
    check("R11", "program suspended bit clear", status[2], 0);
    bus_write(16'h0000, 16'h0020);
    bus_write(16'h0000, 16'h00D0);
    check("R11", "resumed busy", status[7], 0);
    check("R11", "erase setup ignored while suspended", op_req, 0);
    tick(OPC - 5);
    check("R11", "remaining time kept", status[7], 0);
    tick(1);
    check("R11", "done after remaining time", status[7], 1);
    check("R11", "suspend bit cleared", status[6], 0);
    bus_write(16'h0000, 16'h0040);
    bus_write(16'h0050, 16'h0001);
    bus_write(16'h0000, 16'h00B0);
    check("R11", "program suspended bit", status[2], 1);
    bus_write(16'h0000, 16'h0098);
    check("R11", "mode change while suspended", rd_mode, 2);
    bus_write(16'h0000, 16'h00D0);
    wait_ready();
  endtask

  // R6: lock actions
  task automatic t_lock();
    bus_write(16'h2000, 16'h0060);
    bus_write(16'h0001, 16'h0001);
    check("R6", "lock kind", op_kind, 5);
    check("R6", "lock address", op_addr, 16'h2000);
    check("R6", "lock not busy", status[7], 1);
    bus_write(16'h2100, 16'h0060);
    bus_write(16'h2100, 16'h00D0);
    check("R6", "unlock kind", op_kind, 6);
    bus_write(16'h2200, 16'h0060);
    bus_write(16'h2200, 16'h002F);
    check("R6", "lock-down kind", op_kind, 7);
    check("R6", "lock-down request", op_req, 1);
  endtask

  // R7: buffered program
  task automatic t_buffer();
    bus_write(16'h0300, 16'h00E8);
    bus_write(16'h0300, 16'h0003);
    for (int i = 0; i < 3; i++) bus_write(16'h0300 + 16'(i), 16'h00AA);
    check("R7", "no request before last word", op_req, 0);
    bus_write(16'h0303, 16'h00AA);
    check("R7", "buffered request", op_req, 1);
    check("R7", "buffered kind", op_kind, 3);
    check("R7", "buffered start address", op_addr, 16'h0300);
    check("R7", "buffered count", op_data, 3);
    wait_ready();
    bus_write(16'h0400, 16'h00E8);
    bus_write(16'h0400, 16'(BMAX));
    check("R7", "count too large flags error", status[4], 1);
    check("R7", "no request on bad count", op_req, 0);
    bus_write(16'h0000, 16'h0050);
  endtask

  // R8: factory program
  task automatic t_efp();
    bus_write(16'h0500, 16'h0080);
    bus_write(16'h0510, 16'h00D0);
    check("R8", "factory program kind", op_kind, 4);
    check("R8", "factory program address", op_addr, 16'h0510);
    wait_ready();
  endtask

  // R9 and R3: sequence error and clearing
  task automatic t_seqerr();
    bus_write(16'h0000, 16'h00FF);
    bus_write(16'h9000, 16'h0020);
    bus_write(16'h9000, 16'h0055);
    check("R9", "error bit set", status[4], 1);
    check("R9", "no request", op_req, 0);
    check("R9", "status mode", rd_mode, 3);
    check("R9", "not busy", status[7], 1);
    bus_write(16'h0000, 16'h00FF);
    check("R3", "error sticky across mode change", status[4], 1);
    bus_write(16'hABCD, 16'h0050);
    check("R3", "error cleared at any address", status[4], 0);
    bus_write(16'h0000, 16'h0080);
    bus_write(16'h0000, 16'h0001);
    check("R9", "factory program bad confirm", status[4], 1);
    bus_write(16'h0000, 16'h0060);
    bus_write(16'h0000, 16'h0077);
    check("R9", "lock bad confirm no request", op_req, 0);
    bus_write(16'h0000, 16'h0050);
  endtask

  // R12: reset aborts a running operation
  task automatic t_abort();
    bus_write(16'h7000, 16'h0020);
    bus_write(16'h7000, 16'h00D0);
    tick(2);
    check("R12", "busy before abort", status[7], 0);
    reset_awake();
    check("R12", "ready after abort", status, 8'h80);
    check("R12", "array mode after abort", rd_mode, 0);
    check("R12", "no pending request", op_req, 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_en   = 1'b0;
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    tick(2);
    t_wake();
    t_modes();
    t_program();
    t_erase_suspend();
    t_lock();
    t_buffer();
    t_efp();
    t_seqerr();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule